// File: doc/BRIEF.md
# Dual-Issue Dispatch Serialization Controller

This block sits between an instruction queue and the execution units of an in-order, dual-issue pipeline. Each cycle it looks at the two oldest queue entries. For each entry it receives a class code, the execution unit the entry needs, a completion tag and the entry's address. It then decides whether zero, one or both entries leave the queue in that cycle. Dispatch stays strictly in program order, so the younger slot never goes without the older one.

An entry can be held back in three ways. The first is unit pressure: the needed unit is not ready, or a single-issue unit was already taken by the older slot in the same cycle. The second is a dispatch-serializing entry that is still waiting to retire. The third is a refetch-serializing entry that is still waiting to retire. The block keeps one outstanding serializing entry and its tag. It compares that tag against the retirement reports from the completion stage. When a refetch-serializing entry retires, the block raises a refetch request for the following sequential address, and the queue holder discards its younger contents.

A flush input (for example a branch redirect) suppresses dispatch in that cycle and cancels any pending serialization. Dispatch resumes once the reloaded queue presents valid entries.

Top module: `dual_dispatch_ctrl`

## Requirements
- R1: After reset no serialization is pending. With the queue empty, `disp_vld` is 0, `stall_why` is 0 (none) and `refetch_req` is 0.
- R2: Both slots dispatch in one cycle (`disp_vld`=2'b11) when both are valid, slot 0 is class 0 (normal), no serialization is pending, and both units are available.
- R3: A slot dispatches only if `unit_rdy` for its unit is 1. When slot 0 is valid and its unit is not ready, nothing dispatches and `stall_why` is 1 (unit busy).
- R4: When both slots need the same unit and that unit has its `unit_single` bit set, only slot 0 dispatches and `stall_why` is 1.
- R5: Dispatch is in order: if slot 0 does not dispatch, slot 1 does not dispatch, whatever its own unit state.
- R6: Class 1 (dispatch-serializing) in slot 0 dispatches alone, and `stall_why` is 2 in that cycle if slot 1 is valid. From the next cycle, nothing dispatches and `stall_why` is 2 until a retirement report on either port carries its tag. Dispatch resumes in the cycle after that report.
- R7: A serializing entry (class 1 or 2) in slot 1 dispatches together with a normal slot-0 entry.
- R8: Retirement reports whose tag does not match the pending tag do not release the stall.
- R9: Class 2 (refetch-serializing) blocks later dispatch with `stall_why` 3. In the cycle its tag retires, `refetch_req` is 1 and `refetch_pc` equals its address plus 4, with no dispatch. Dispatch resumes in the next cycle.
- R10: While `flush` is 1, nothing dispatches, `stall_why` is 0 and `refetch_req` is 0. Any pending serialization is cleared at that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Flow-change flush; cancels pending serialization |
| q_vld | input | 2 | Valid bits of the two oldest queue entries (bit 0 oldest) |
| q_cls0 | input | 2 | Slot 0 class: 0 normal, 1 dispatch-serializing, 2 refetch-serializing |
| q_cls1 | input | 2 | Slot 1 class, same encoding |
| q_unit0 | input | UNIT_W | Unit index needed by slot 0 |
| q_unit1 | input | UNIT_W | Unit index needed by slot 1 |
| q_tag0 | input | TAG_W | Completion tag of slot 0 |
| q_tag1 | input | TAG_W | Completion tag of slot 1 |
| q_pc0 | input | ADDR_W | Address of slot 0 |
| q_pc1 | input | ADDR_W | Address of slot 1 |
| unit_rdy | input | N_UNITS | Per-unit ready this cycle |
| unit_single | input | N_UNITS | Per-unit flag: accepts one entry per cycle |
| ret_vld | input | N_RET | Retirement report valid per port |
| ret_tag | input | N_RET*TAG_W | Retirement tags, port k at bits [k*TAG_W +: TAG_W] |
| disp_vld | output | 2 | Dispatch strobes per slot |
| stall_why | output | 2 | 0 none, 1 unit busy, 2 serialization wait, 3 refetch pending |
| refetch_req | output | 1 | Refetch request; queue discards younger entries |
| refetch_pc | output | ADDR_W | Refetch start address |

## Verification
The embedded properties check these on every cycle: in-order strobes, dispatch only to a ready unit, no double use of a single-issue unit, the hold after a dispatch-serializing entry, and that refetch and flush clear the pending state. Tag matching on either retirement port, rejection of wrong tags, the refetch address and the exact cycle dispatch resumes can only be shown by the bench's directed sequences. The exact stall code for every mix of classes, unit indices and ready patterns is shown by the bench's sweep.

// File: rtl/dd_pkg.sv
package dd_pkg;
  typedef enum logic [1:0] {
    CLS_NORM = 2'd0,
    CLS_DSER = 2'd1,
    CLS_RSER = 2'd2
  } cls_e;

  typedef enum logic [1:0] {
    RSN_NONE = 2'd0,
    RSN_UNIT = 2'd1,
    RSN_SER  = 2'd2,
    RSN_RF   = 2'd3
  } rsn_e;

  localparam int unsigned INSN_BYTES = 4;
endpackage

// File: rtl/dd_unit_gate.sv
module dd_unit_gate #(
  parameter int N_UNITS = 4,
  localparam int UNIT_W = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic [N_UNITS-1:0] unit_rdy,
  input  logic [N_UNITS-1:0] unit_single,
  input  logic [UNIT_W-1:0]  u0,
  input  logic [UNIT_W-1:0]  u1,
  output logic               ok0,
  output logic               ok1
);
  logic shared_single;

  always_comb begin
    shared_single = unit_single[u1] && (u1 == u0);
    ok0 = unit_rdy[u0];
    // slot 1 is only considered when slot 0 also issues this cycle
    ok1 = unit_rdy[u1] && !shared_single;
  end
endmodule

// File: rtl/dd_tag_match.sv
module dd_tag_match #(
  parameter int N_RET = 2,
  parameter int TAG_W = 4
) (
  input  logic [N_RET-1:0]       ret_vld,
  input  logic [N_RET*TAG_W-1:0] ret_tag,
  input  logic [TAG_W-1:0]       want,
  output logic                   hit
);
  logic [N_RET-1:0] lane_hit;

  for (genvar k = 0; k < N_RET; k++) begin : g_lane
    assign lane_hit[k] = ret_vld[k] && (ret_tag[k*TAG_W +: TAG_W] == want);
  end

  assign hit = |lane_hit;
endmodule

// File: rtl/dd_serial_track.sv
module dd_serial_track
  import dd_pkg::*;
#(
  parameter int TAG_W  = 4,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              cap_en,
  input  cls_e              cap_cls,
  input  logic [TAG_W-1:0]  cap_tag,
  input  logic [ADDR_W-1:0] cap_npc,
  input  logic              hit,
  output cls_e              pend_cls,
  output logic [TAG_W-1:0]  pend_tag,
  output logic [ADDR_W-1:0] pend_npc
);
  cls_e              cls_d;
  logic [TAG_W-1:0]  tag_d;
  logic [ADDR_W-1:0] npc_d;
  logic              ld_en;
  logic              pending;

  assign pending = (pend_cls != CLS_NORM);

  always_comb begin
    cls_d = pend_cls;
    tag_d = pend_tag;
    npc_d = pend_npc;
    ld_en = 1'b0;
    if (flush || (pending && hit)) begin
      cls_d = CLS_NORM;
      ld_en = 1'b1;
    end else if (cap_en && !pending) begin
      cls_d = cap_cls;
      tag_d = cap_tag;
      npc_d = cap_npc;
      ld_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_cls <= CLS_NORM;
      pend_tag <= '0;
      pend_npc <= '0;
    end else if (ld_en) begin
      pend_cls <= cls_d;
      pend_tag <= tag_d;
      pend_npc <= npc_d;
    end
  end

  p_flush_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (pend_cls == CLS_NORM));

  p_rf_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_cls == CLS_RSER && hit) |=> (pend_cls == CLS_NORM));

  p_tag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !hit && !flush) |=> ($stable(pend_tag) && $stable(pend_cls)));
endmodule

// File: rtl/dual_dispatch_ctrl.sv
module dual_dispatch_ctrl
  import dd_pkg::*;
#(
  parameter int N_UNITS = 4,
  parameter int TAG_W   = 4,
  parameter int ADDR_W  = 32,
  parameter int N_RET   = 2,
  localparam int UNIT_W = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic [1:0]             q_vld,
  input  logic [1:0]             q_cls0,
  input  logic [1:0]             q_cls1,
  input  logic [UNIT_W-1:0]      q_unit0,
  input  logic [UNIT_W-1:0]      q_unit1,
  input  logic [TAG_W-1:0]       q_tag0,
  input  logic [TAG_W-1:0]       q_tag1,
  input  logic [ADDR_W-1:0]      q_pc0,
  input  logic [ADDR_W-1:0]      q_pc1,
  input  logic [N_UNITS-1:0]     unit_rdy,
  input  logic [N_UNITS-1:0]     unit_single,
  input  logic [N_RET-1:0]       ret_vld,
  input  logic [N_RET*TAG_W-1:0] ret_tag,
  output logic [1:0]             disp_vld,
  output logic [1:0]             stall_why,
  output logic                   refetch_req,
  output logic [ADDR_W-1:0]      refetch_pc
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  cls_e              c0, c1;
  cls_e              pend_cls;
  logic [TAG_W-1:0]  pend_tag;
  logic [ADDR_W-1:0] pend_npc;
  logic              ok0, ok1, hit, pending;
  logic              go0, go1;
  logic              cap_en;
  cls_e              cap_cls;
  logic [TAG_W-1:0]  cap_tag;
  logic [ADDR_W-1:0] cap_npc;
  rsn_e              rsn;

  assign c0 = (q_cls0 == 2'd1) ? CLS_DSER : (q_cls0 == 2'd2) ? CLS_RSER : CLS_NORM;
  assign c1 = (q_cls1 == 2'd1) ? CLS_DSER : (q_cls1 == 2'd2) ? CLS_RSER : CLS_NORM;
  assign pending = (pend_cls != CLS_NORM);

  dd_unit_gate #(.N_UNITS(N_UNITS)) u_gate (
    .unit_rdy    (unit_rdy),
    .unit_single (unit_single),
    .u0          (q_unit0),
    .u1          (q_unit1),
    .ok0         (ok0),
    .ok1         (ok1)
  );

  dd_tag_match #(.N_RET(N_RET), .TAG_W(TAG_W)) u_match (
    .ret_vld (ret_vld),
    .ret_tag (ret_tag),
    .want    (pend_tag),
    .hit     (hit)
  );

  dd_serial_track #(.TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .cap_en   (cap_en),
    .cap_cls  (cap_cls),
    .cap_tag  (cap_tag),
    .cap_npc  (cap_npc),
    .hit      (hit),
    .pend_cls (pend_cls),
    .pend_tag (pend_tag),
    .pend_npc (pend_npc)
  );

  // issue decision, strictly in order
  always_comb begin
    go0 = !flush && !pending && q_vld[0] && ok0;
    go1 = go0 && (c0 == CLS_NORM) && q_vld[1] && ok1;
  end

  // capture of the serializing entry that leaves this cycle
  always_comb begin
    cap_en  = 1'b0;
    cap_cls = CLS_NORM;
    cap_tag = q_tag0;
    cap_npc = q_pc0 + STEP;
    if (go0 && c0 != CLS_NORM) begin
      cap_en  = 1'b1;
      cap_cls = c0;
    end else if (go1 && c1 != CLS_NORM) begin
      cap_en  = 1'b1;
      cap_cls = c1;
      cap_tag = q_tag1;
      cap_npc = q_pc1 + STEP;
    end
  end

  // stall cause of the oldest entry left behind
  always_comb begin
    rsn = RSN_NONE;
    if (flush) begin
      rsn = RSN_NONE;
    end else if (pending) begin
      rsn = (pend_cls == CLS_RSER) ? RSN_RF : RSN_SER;
    end else if (q_vld[0] && !ok0) begin
      rsn = RSN_UNIT;
    end else if (go0 && q_vld[1] && c0 != CLS_NORM) begin
      rsn = (c0 == CLS_RSER) ? RSN_RF : RSN_SER;
    end else if (go0 && q_vld[1] && !ok1) begin
      rsn = RSN_UNIT;
    end
  end

  assign disp_vld    = {go1, go0};
  assign stall_why   = rsn;
  assign refetch_req = !flush && (pend_cls == CLS_RSER) && hit;
  assign refetch_pc  = pend_npc;

  p_in_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    disp_vld[1] |-> disp_vld[0]);

  p_unit_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    disp_vld[0] |-> unit_rdy[q_unit0]);

  p_single_issue_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_vld == 2'b11 && q_unit0 == q_unit1) |-> !unit_single[q_unit0]);

  p_ser_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_vld[0] && q_cls0 == 2'd1 && !flush) |=> (disp_vld == 2'b00));

  p_flush_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (disp_vld == 2'b00 && !refetch_req));
endmodule

// File: tb/tb_dual_dispatch_ctrl.sv
`timescale 1ns/1ps
module tb_dual_dispatch_ctrl;
  localparam int NU = 4, TW = 4, AW = 32, NR = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          flush;
  logic [1:0]    q_vld, q_cls0, q_cls1;
  logic [1:0]    q_unit0, q_unit1;
  logic [TW-1:0] q_tag0, q_tag1;
  logic [AW-1:0] q_pc0, q_pc1;
  logic [NU-1:0] unit_rdy, unit_single;
  logic [NR-1:0] ret_vld;
  logic [NR*TW-1:0] ret_tag;
  logic [1:0]    disp_vld, stall_why;
  logic          refetch_req;
  logic [AW-1:0] refetch_pc;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dual_dispatch_ctrl #(.N_UNITS(NU), .TAG_W(TW), .ADDR_W(AW), .N_RET(NR)) dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .q_vld(q_vld),
    .q_cls0(q_cls0), .q_cls1(q_cls1), .q_unit0(q_unit0), .q_unit1(q_unit1),
    .q_tag0(q_tag0), .q_tag1(q_tag1), .q_pc0(q_pc0), .q_pc1(q_pc1),
    .unit_rdy(unit_rdy), .unit_single(unit_single), .ret_vld(ret_vld),
    .ret_tag(ret_tag), .disp_vld(disp_vld), .stall_why(stall_why),
    .refetch_req(refetch_req), .refetch_pc(refetch_pc));

  task automatic chk(input string req, input logic [1:0] ed, input logic [1:0] er,
                     input logic erf);
    n_chk++;
    if (disp_vld !== ed || stall_why !== er || refetch_req !== erf) begin
      n_bad++;
      $display("FAIL %s: disp=%b why=%0d rf=%b expected disp=%b why=%0d rf=%b",
               req, disp_vld, stall_why, refetch_req, ed, er, erf);
    end
  endtask

  task automatic chk_pc(input string req, input logic [AW-1:0] e);
    n_chk++;
    if (refetch_pc !== e) begin
      n_bad++;
      $display("FAIL %s: refetch_pc=%h expected %h", req, refetch_pc, e);
    end
  endtask

  task automatic idle_in();
    flush = 0; q_vld = 0; q_cls0 = 0; q_cls1 = 0; q_unit0 = 0; q_unit1 = 1;
    q_tag0 = 0; q_tag1 = 0; q_pc0 = 0; q_pc1 = 0;
    unit_rdy = '1; unit_single = '0; ret_vld = 0; ret_tag = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4ns * 200000);
    n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    idle_in();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R1 reset", 2'b00, 2'd0, 1'b0);

    // R2 R3 R4 R5 R7 sweep from the idle state
    unit_single = 4'b0101;
    for (int v = 0; v < 4; v++)
      for (int a = 0; a < 3; a++)
        for (int b = 0; b < 3; b++)
          for (int x = 0; x < 4; x++)
            for (int y = 0; y < 4; y++)
              for (int r = 0; r < 16; r++) begin
                logic k0, k1, e0, e1;
                logic [1:0] er, pr;
                @(negedge clk);
                flush = 0; q_vld = 2'(v); q_cls0 = 2'(a); q_cls1 = 2'(b);
                q_unit0 = 2'(x); q_unit1 = 2'(y); unit_rdy = 4'(r);
                q_tag0 = 4'd5; q_tag1 = 4'd6; q_pc0 = 32'h1000; q_pc1 = 32'h1004;
                k0 = unit_rdy[x];
                k1 = unit_rdy[y] && !(unit_single[y] && x == y);
                e0 = q_vld[0] && k0;
                e1 = e0 && a == 0 && q_vld[1] && k1;
                er = 2'd0;
                if (q_vld[0] && !k0) er = 2'd1;
                else if (e0 && q_vld[1] && a != 0) er = (a == 2) ? 2'd3 : 2'd2;
                else if (e0 && q_vld[1] && !k1) er = 2'd1;
                pr = 2'd0;
                if (e0 && a != 0) pr = (a == 2) ? 2'd3 : 2'd2;
                else if (e1 && b != 0) pr = (b == 2) ? 2'd3 : 2'd2;
                #1;
                chk("R2/R3/R4/R5/R7 sweep", {e1, e0}, er, 1'b0);
                if (pr != 0) begin
                  @(negedge clk); q_vld = 0; #1;
                  chk("R6/R9 pending after sweep", 2'b00, pr, 1'b0);
                  @(negedge clk); flush = 1; q_vld = 2'b11; #1;
                  chk("R10 flush quiet", 2'b00, 2'd0, 1'b0);
                end
              end

    // R6 R8 dispatch-serializing hold, release on port 1
    @(negedge clk); idle_in();
    q_vld = 2'b11; q_cls0 = 1; q_tag0 = 4'd3; q_tag1 = 4'd4; #1;
    chk("R6 ser slot0 alone", 2'b01, 2'd2, 1'b0);
    @(negedge clk); q_cls0 = 0; q_tag0 = 4'd4; #1;
    chk("R6 hold", 2'b00, 2'd2, 1'b0);
    @(negedge clk); ret_vld = 2'b01; ret_tag = {4'd0, 4'd4}; #1;
    chk("R8 wrong tag", 2'b00, 2'd2, 1'b0);
    @(negedge clk); ret_vld = 2'b11; ret_tag = {4'd9, 4'd7}; #1;
    chk("R8 wrong tags both", 2'b00, 2'd2, 1'b0);
    @(negedge clk); ret_vld = 2'b10; ret_tag = {4'd3, 4'd0}; #1;
    chk("R6 release cycle", 2'b00, 2'd2, 1'b0);
    @(negedge clk); ret_vld = 0; #1;
    chk("R6 resume", 2'b11, 2'd0, 1'b0);

    // R7 R9 refetch-serializing in slot 1
    @(negedge clk); idle_in();
    q_vld = 2'b11; q_cls1 = 2; q_tag1 = 4'd11; q_pc1 = 32'h2000; #1;
    chk("R7 ser slot1 pairs", 2'b11, 2'd0, 1'b0);
    @(negedge clk); q_cls1 = 0; #1;
    chk("R9 hold", 2'b00, 2'd3, 1'b0);
    @(negedge clk); ret_vld = 2'b01; ret_tag = {4'd0, 4'd10}; #1;
    chk("R8 wrong tag rf", 2'b00, 2'd3, 1'b0);
    @(negedge clk); ret_tag = {4'd0, 4'd11}; #1;
    chk("R9 refetch", 2'b00, 2'd3, 1'b1);
    chk_pc("R9 refetch pc", 32'h2004);
    @(negedge clk); ret_vld = 0; q_vld = 0; #1;
    chk("R9 after refetch", 2'b00, 2'd0, 1'b0);
    @(negedge clk); q_vld = 2'b01; #1;
    chk("R9 resume", 2'b01, 2'd0, 1'b0);

    // R10 flush cancels pending and suppresses refetch
    @(negedge clk); idle_in();
    q_vld = 2'b01; q_cls0 = 2; q_tag0 = 4'd2; q_pc0 = 32'h3000; #1;
    chk("R9 rf slot0", 2'b01, 2'd0, 1'b0);
    @(negedge clk); q_cls0 = 0; q_vld = 2'b11; flush = 1;
    ret_vld = 2'b01; ret_tag = {4'd0, 4'd2}; #1;
    chk("R10 flush over refetch", 2'b00, 2'd0, 1'b0);
    @(negedge clk); flush = 0; ret_vld = 0; #1;
    chk("R10 cleared", 2'b11, 2'd0, 1'b0);

    @(negedge clk);
    finish_run();
  end
endmodule